// File: doc/BRIEF.md
# Double-Buffered PWM Channel

A single pulse-width modulation channel built around a 16-bit up-counter that runs left-aligned: it counts from zero up to the live period value, then starts over at zero. The channel output is at the active level while the count is below the live duty value, and at the inactive level for the rest of the period. A polarity input chooses which logic level counts as active.

The live period and duty registers cannot be changed mid-period. Software writes a new value into one shared staging register and gives a target bit with it. The staged value waits there, with a pending flag set, until the counter wraps. At that boundary it is copied into the duty register or into the period register, as the target bit selects. This way the waveform never shows a partial or glitched period. Starting the channel loads both live registers from the initial-value inputs and clears the counter. While the channel is off, the counter stays at zero and the output stays at the inactive level.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: In the cycle after `chan_en` rises, the counter reads 0 and the live period and duty hold the values that `init_period` and `init_duty` had at the rising edge.
- R2: While enabled, the counter goes up by one each cycle. In the cycle after it equals the live period it reads 0, so each period lasts period+1 cycles. A period of 0 keeps the counter at 0.
- R3: An update write does not change the live period or duty before the next wrap. The waveform keeps its current shape until the counter returns to 0.
- R4: If the pending value carries target bit `upd_tgt` = 0, it is copied into the live duty register at the wrap.
- R5: If the pending value carries target bit `upd_tgt` = 1, it is copied into the live period register at the wrap.
- R6: `upd_pending` reads 1 in the cycle after an update write. It reads 0 in the cycle after the value is committed, unless a new write came at the same edge. A second write before the commit replaces both the staged value and its target bit. A write in the wrap cycle is held for the next wrap.
- R7: While enabled, `pwm_out` equals `polarity` when the counter is below the live duty, and `~polarity` otherwise.
- R8: If the live duty is greater than or equal to the live period, `pwm_out` stays at `polarity` (active) for the whole period, including the cycle in which the counter equals the period.
- R9: While disabled, `cnt_out` is 0 and `pwm_out` is `~polarity`. A staged update stays pending while the channel is off and is committed at the first wrap after the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel run enable (level) |
| init_period | input | 16 | Period loaded when the channel starts |
| init_duty | input | 16 | Duty loaded when the channel starts |
| upd_wr | input | 1 | Write strobe for the shared update register |
| upd_data | input | 16 | Value written to the update register |
| upd_tgt | input | 1 | Target of the write: 0 duty, 1 period |
| polarity | input | 1 | Active output level |
| cnt_out | output | 16 | Read-only counter value |
| pwm_out | output | 1 | PWM waveform |
| upd_pending | output | 1 | A staged update is waiting for the next wrap |

## Verification
The bench uses the default counter width of 16 with periods kept below 25. This makes every wrap, commit and overwrite occur within a few hundred cycles. The small periods bring within reach the boundary cases: a period of zero (a wrap on every cycle), duty equal to the period, duty above the period, a write that lands in the wrap cycle itself, and a channel disable with a write still pending. A behavioural model in the bench predicts the counter, the output and the pending flag on every clock, under both polarities.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  // Destination of a staged update value
  typedef enum logic {
    TGT_DUTY   = 1'b0,
    TGT_PERIOD = 1'b1
  } upd_tgt_e;
endpackage

// File: rtl/pwm_upd_hold.sv
module pwm_upd_hold
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         wtgt,
  input  logic         commit,
  output logic         pending,
  output logic [W-1:0] hold_val,
  output upd_tgt_e     hold_tgt
);
  // A new write always wins the pending flag, even in a commit cycle
  function automatic logic next_pending(input logic w, input logic c, input logic p);
    if (w) return 1'b1;
    if (c) return 1'b0;
    return p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      hold_val <= '0;
      hold_tgt <= TGT_DUTY;
    end else begin
      pending <= next_pending(wr, commit, pending);
      if (wr) begin
        hold_val <= wdata;
        hold_tgt <= upd_tgt_e'(wtgt);
      end
    end
  end

  assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> pending && hold_val == $past(wdata));
  assert_pend_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr) |=> !pending);
  assert_pend_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !wr) |=> $stable(pending) && $stable(hold_val));
endmodule

// File: rtl/pwm_live_regs.sv
module pwm_live_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] init_period,
  input  logic [W-1:0] init_duty,
  input  logic         commit,
  input  logic [W-1:0] hold_val,
  input  upd_tgt_e     hold_tgt,
  output logic [W-1:0] period,
  output logic [W-1:0] duty
);
  wire commit_period = commit && (hold_tgt == TGT_PERIOD);
  wire commit_duty   = commit && (hold_tgt == TGT_DUTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= '0;
      duty   <= '0;
    end else if (start) begin
      period <= init_period;
      duty   <= init_duty;
    end else begin
      if (commit_period) period <= hold_val;
      if (commit_duty)   duty   <= hold_val;
    end
  end

  assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> period == $past(init_period) && duty == $past(init_duty));
  assert_no_midperiod_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !commit) |=> $stable(period) && $stable(duty));
  assert_duty_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_duty |=> duty == $past(hold_val) && $stable(period));
  assert_period_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_period |=> period == $past(hold_val) && $stable(duty));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic [W-1:0] period,
  output logic         en_q,
  output logic [W-1:0] cnt,
  output logic         start,
  output logic         wrap
);
  function automatic logic [W-1:0] next_count(input logic run, input logic st,
                                              input logic wr_, input logic [W-1:0] c);
    if (!run || st || wr_) return '0;
    return c + W'(1);
  endfunction

  assign start = chan_en && !en_q;
  assign wrap  = en_q && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      cnt  <= '0;
    end else begin
      en_q <= chan_en;
      cnt  <= next_count(chan_en, start, wrap, cnt);
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> cnt <= period);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && chan_en && !wrap) |=> cnt == $past(cnt) + W'(1));
  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  assert_cnt_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> en_q && cnt == '0);
  assert_cnt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> cnt == '0);
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_q,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  input  logic         polarity,
  output logic         pwm
);
  function automatic logic is_active(input logic [W-1:0] c, input logic [W-1:0] p,
                                     input logic [W-1:0] d);
    return (c < d) || (d >= p);
  endfunction

  logic active;
  always_comb begin
    active = en_q && is_active(cnt, period, duty);
    pwm    = active ? polarity : ~polarity;
  end

  assert_full_duty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && duty >= period) |-> pwm == polarity);
  assert_tail_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && duty < period && cnt >= duty) |-> pwm == ~polarity);
  assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> pwm == ~polarity);
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic [CNT_W-1:0] init_period,
  input  logic [CNT_W-1:0] init_duty,
  input  logic             upd_wr,
  input  logic [CNT_W-1:0] upd_data,
  input  logic             upd_tgt,
  input  logic             polarity,
  output logic [CNT_W-1:0] cnt_out,
  output logic             pwm_out,
  output logic             upd_pending
);
  // Internal events brought out for the assertions
  logic             en_q;
  logic             start_ev;
  logic             wrap_ev;
  logic             commit_ev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] duty;
  logic [CNT_W-1:0] hold_val;
  upd_tgt_e         hold_tgt;

  assign commit_ev = wrap_ev && upd_pending;

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .period(period),
    .en_q(en_q), .cnt(cnt), .start(start_ev), .wrap(wrap_ev)
  );

  pwm_upd_hold #(.W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr(upd_wr), .wdata(upd_data), .wtgt(upd_tgt),
    .commit(commit_ev), .pending(upd_pending), .hold_val(hold_val), .hold_tgt(hold_tgt)
  );

  pwm_live_regs #(.W(CNT_W)) u_live (
    .clk(clk), .rst_n(rst_n), .start(start_ev), .init_period(init_period),
    .init_duty(init_duty), .commit(commit_ev), .hold_val(hold_val),
    .hold_tgt(hold_tgt), .period(period), .duty(duty)
  );

  pwm_wave #(.W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .cnt(cnt), .period(period),
    .duty(duty), .polarity(polarity), .pwm(pwm_out)
  );

  assign cnt_out = cnt;

  assert_commit_only_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && !wrap_ev && !upd_wr) |=> upd_pending);
endmodule

// File: tb/pwm_dbuf_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_dbuf_chan_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chan_en = 1'b0;
  logic [W-1:0] init_period = '0;
  logic [W-1:0] init_duty = '0;
  logic         upd_wr = 1'b0;
  logic [W-1:0] upd_data = '0;
  logic         upd_tgt = 1'b0;
  logic         polarity = 1'b1;
  logic [W-1:0] cnt_out;
  logic         pwm_out;
  logic         upd_pending;

  always #4 clk = ~clk;

  pwm_dbuf_chan #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .init_period(init_period),
    .init_duty(init_duty), .upd_wr(upd_wr), .upd_data(upd_data), .upd_tgt(upd_tgt),
    .polarity(polarity), .cnt_out(cnt_out), .pwm_out(pwm_out), .upd_pending(upd_pending)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R9";

  // Behavioural reference model
  int m_en = 0, m_cnt = 0, m_per = 0, m_duty = 0, m_pend = 0, m_hold = 0, m_tgt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_cnt = 0; m_per = 0; m_duty = 0; m_pend = 0; m_hold = 0; m_tgt = 0;
    end else begin
      int at_wrap;
      int fire;
      at_wrap = (m_en != 0) && (m_cnt == m_per);
      fire = at_wrap && (m_pend != 0);
      if (chan_en && m_en == 0) begin
        m_per = init_period; m_duty = init_duty;
      end else if (fire) begin
        if (m_tgt == 1) m_per = m_hold; else m_duty = m_hold;
      end
      if (!chan_en || m_en == 0 || at_wrap) m_cnt = 0; else m_cnt = m_cnt + 1;
      if (upd_wr) begin
        m_pend = 1; m_hold = upd_data; m_tgt = upd_tgt;
      end else if (fire) m_pend = 0;
      m_en = chan_en;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_pwm();
    if (m_en == 0) return polarity ? 0 : 1;
    if (m_cnt < m_duty || m_duty >= m_per) return polarity;
    return polarity ? 0 : 1;
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(int'(cnt_out) == m_cnt, tag, "cnt_out", int'(cnt_out), m_cnt);
      check(int'(pwm_out) == exp_pwm(), tag, "pwm_out", int'(pwm_out), exp_pwm());
      check(int'(upd_pending) == m_pend, tag, "upd_pending", int'(upd_pending), m_pend);
    end
  endtask

  task automatic write_upd(input int val, input bit tgt);
    upd_wr = 1'b1; upd_data = W'(val); upd_tgt = tgt;
    tick(1);
    upd_wr = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 200 && int'(cnt_out) != v; i++) tick(1);
  endtask

  initial begin
    tag = "R9";
    tick(3);
    rst_n = 1'b1;
    tick(3);
    check(cnt_out == '0, "R9", "reset cnt", int'(cnt_out), 0);
    check(pwm_out == 1'b0, "R9", "reset pwm inactive", int'(pwm_out), 0);

    // R1 / R2 / R7: start with period 9, duty 4
    tag = "R1";
    init_period = 16'd9; init_duty = 16'd4; chan_en = 1'b1;
    tick(1);
    check(cnt_out == '0, "R1", "cnt after start", int'(cnt_out), 0);
    tag = "R2"; tick(12);
    tag = "R7"; tick(12);

    // R3 / R4: duty update mid-period, not visible until wrap
    tag = "R3";
    wait_cnt(2);
    write_upd(7, 1'b0);
    tick(6);
    tag = "R4"; tick(22);

    // R5: period update
    tag = "R5";
    write_upd(5, 1'b1);
    tick(25);

    // R6: overwrite before commit; final value/target wins
    tag = "R6";
    wait_cnt(1);
    write_upd(12, 1'b1);
    write_upd(3, 1'b0);
    check(upd_pending == 1'b1, "R6", "pending after writes", int'(upd_pending), 1);
    tick(20);
    // write landing in the wrap cycle is held for the next wrap
    wait_cnt(5);
    write_upd(2, 1'b0);
    tick(14);

    // R8: duty above and equal to period, both polarities
    tag = "R8";
    write_upd(30, 1'b0);
    tick(16);
    write_upd(5, 1'b0);
    tick(16);
    polarity = 1'b0;
    tick(12);
    write_upd(0, 1'b1);      // period 0: wrap on every cycle
    tick(6);
    tag = "R2";
    write_upd(6, 1'b1);
    tick(10);
    write_upd(2, 1'b0);
    tick(18);

    // R9: disable with an update pending, then restart
    tag = "R9";
    wait_cnt(3);
    write_upd(4, 1'b1);
    chan_en = 1'b0;
    tick(5);
    check(upd_pending == 1'b1, "R9", "pending kept while off", int'(upd_pending), 1);
    check(pwm_out == 1'b1, "R9", "idle level pol=0", int'(pwm_out), 1);
    tag = "R1";
    init_period = 16'd10; init_duty = 16'd6; polarity = 1'b1;
    chan_en = 1'b1;
    tick(30);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule